// File: doc/BRIEF.md
# RDS Bit Buffer with Master and Slave Serial Readout

This block sits behind an RDS bit recovery stage. Each decoded data bit arrives with a strobe and a reliability flag. The block keeps the bit and its flag in a circular store of 128 entries, which holds roughly 100 ms of broadcast data. Bits leave the block over two wires: a serial clock and a serial data line. A third line, the flag pin, carries status.

Readout works in one of two ways.

- **Master readout.** The block generates the serial clock itself, at the RDS bit rate. The flag pin carries the reliability bit of the data bit currently on the line.
- **Slave readout.** An external controller drives the serial clock. The flag pin becomes a ready indication, and the controller clocks bits out only while ready is high.

The controller may change the readout mode between bits without skipping or repeating a bit. A test input stops all activity.

After a reset the store stays closed until the first reliable bit arrives. From that point on, every strobed bit is kept, whatever its flag. The bidirectional clock pad is modelled as an input, an output and an output enable. The system clock is 4.332 MHz. One RDS bit therefore lasts 3648 cycles, split into two halves of 1824 cycles.

Top module: `rds_readout_buffer`

## Requirements
- R1: A synchronous active-high reset empties the store and clears the armed state. Right after reset, slave readout shows `flag_out`=0 (not ready).
- R2: After reset, strobed bits with `bit_rel`=0 are discarded until the first strobed bit with `bit_rel`=1. That bit is stored, and every later strobed bit is stored regardless of `bit_rel`.
- R3: The store holds DEPTH bits. A bit written while the store is full replaces the oldest unread bit, so readout returns the newest DEPTH bits in arrival order.
- R4: Master readout is selected by `test_sel`=0 and `mode_sel`=0. In this mode `sclk_oe`=1. While bits are waiting, each bit occupies exactly 2*HALF_CYCLES cycles: `sclk_out` is high for HALF_CYCLES cycles, then low for HALF_CYCLES cycles. `sdata_out` holds the bit and `flag_out` holds its reliability flag across the falling edge of `sclk_out`.
- R5: In master readout with nothing stored, `sclk_out` stays high and produces no falling edge.
- R6: In master readout after reset, `sclk_out` and `sdata_out` both stay high until the first reliable bit arms the store.
- R7: Slave readout is selected by `test_sel`=0 and `mode_sel`=1. In this mode `sclk_oe`=0, `flag_out` is high exactly when at least one unread bit is stored, and `sdata_out` shows the oldest unread bit.
- R8: In slave readout, each falling edge of `sclk_in` (seen after a two-flop synchronizer) retires one bit and presents the next. A rising edge changes nothing.
- R9: Falling edges of `sclk_in` while no bit is stored have no effect. The next bit written is the next bit read.
- R10: A readout mode change between bits loses and repeats nothing. If master readout delivered bit n, slave readout presents bit n+1, and the reverse holds as well.
- R11: With `test_sel`=1 the store, the pointers and the readout state are frozen. Strobes and `sclk_in` edges are ignored, and `sclk_oe`, `sclk_out`, `sdata_out` and `flag_out` are all 0. Stored bits survive and resume when `test_sel` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4.332 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | One-cycle strobe for a decoded bit |
| bit_data | input | 1 | Decoded RDS data bit |
| bit_rel | input | 1 | Reliability flag of the bit (1 = reliable) |
| mode_sel | input | 1 | Readout mode: 0 master, 1 slave |
| test_sel | input | 1 | 1 freezes the block (standby or reserved test) |
| sclk_in | input | 1 | Serial clock from the pad (slave readout) |
| sclk_out | output | 1 | Serial clock driven in master readout |
| sclk_oe | output | 1 | Drive enable for the serial clock pad |
| sdata_out | output | 1 | Serial data |
| flag_out | output | 1 | Reliability bit (master) or ready (slave) |

## Verification
The following are checked on every cycle:

- The fill level never exceeds DEPTH.
- An empty store never underflows.
- The armed state never drops without a reset.
- The outputs stay high before arming in master readout.
- Serial data is stable across each master falling edge.
- The store is frozen while the test input is high.

The rest can only be seen through the bench's scenarios:

- the exact bit order after overwrite,
- the precise bit period,
- delivery continuing as n+1 across mode changes in either direction,
- discarding of unreliable bits before arming,
- edges ignored while not ready.

// File: rtl/rdsrb_pkg.sv
package rdsrb_pkg;

    typedef struct packed {
        logic data;
        logic rel;
    } rds_bit_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HIGH,
        PH_LOW
    } mphase_e;

    typedef enum logic [1:0] {
        OP_MASTER,
        OP_SLAVE,
        OP_TESTRES,
        OP_STANDBY
    } opmode_e;

    function automatic opmode_e decode_op(input logic test, input logic mode);
        opmode_e r;
        case ({test, mode})
            2'b00:   r = OP_MASTER;
            2'b01:   r = OP_SLAVE;
            2'b10:   r = OP_TESTRES;
            default: r = OP_STANDBY;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rdsrb_store.sv
module rdsrb_store
    import rdsrb_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          wr_valid,
    input  rds_bit_t      wr_entry,
    input  logic          pop,
    output rds_bit_t      head,
    output logic [CW-1:0] fill,
    output logic          armed
);

    rds_bit_t      mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] fill_q;
    logic          armed_q;
    logic          full;
    logic          do_write;
    logic          do_pop;
    logic          rd_adv;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full     = (fill_q == CW'(DEPTH));
    assign do_write = run && wr_valid && (armed_q || wr_entry.rel);
    assign do_pop   = run && pop && (fill_q != '0);
    assign rd_adv   = do_pop || (do_write && full);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            fill_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            if (run && wr_valid && wr_entry.rel) begin
                armed_q <= 1'b1;
            end
            if (do_write) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (rd_adv) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({do_write, do_pop})
                2'b10:   fill_q <= full ? fill_q : fill_q + CW'(1);
                2'b01:   fill_q <= fill_q - CW'(1);
                default: fill_q <= fill_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_write) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    assign head  = mem[rd_ptr];
    assign fill  = fill_q;
    assign armed = armed_q;

endmodule

// File: rtl/rdsrb_master.sv
module rdsrb_master
    import rdsrb_pkg::*;
#(
    parameter int HALF_CYCLES = 1824,
    localparam int TW = $clog2(HALF_CYCLES + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     enable,
    input  logic     armed,
    input  logic     avail,
    input  rds_bit_t head,
    output logic     pop,
    output logic     sclk,
    output logic     sdata,
    output logic     rel
);

    localparam logic [TW-1:0] LAST = TW'(HALF_CYCLES - 1);

    mphase_e       phase;
    logic [TW-1:0] tcnt;
    logic          sclk_q;
    logic          data_q;
    logic          rel_q;
    logic          ready_bit;
    logic          slot_open;
    logic          load;

    assign ready_bit = armed && avail;
    assign slot_open = (phase == PH_IDLE) || ((phase == PH_LOW) && (tcnt == LAST));
    assign load      = run && enable && ready_bit && slot_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            tcnt   <= '0;
            sclk_q <= 1'b1;
            data_q <= 1'b1;
            rel_q  <= 1'b0;
        end else if (run) begin
            if (!enable) begin
                phase  <= PH_IDLE;
                tcnt   <= '0;
                sclk_q <= 1'b1;
            end else if (load) begin
                phase  <= PH_HIGH;
                tcnt   <= '0;
                sclk_q <= 1'b1;
                data_q <= head.data;
                rel_q  <= head.rel;
            end else begin
                case (phase)
                    PH_HIGH: begin
                        if (tcnt == LAST) begin
                            tcnt   <= '0;
                            sclk_q <= 1'b0;
                            phase  <= PH_LOW;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                    PH_LOW: begin
                        if (tcnt == LAST) begin
                            tcnt   <= '0;
                            sclk_q <= 1'b1;
                            phase  <= PH_IDLE;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                    default: begin
                        tcnt   <= '0;
                        sclk_q <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign pop   = load;
    assign sclk  = sclk_q;
    assign sdata = data_q;
    assign rel   = rel_q;

endmodule

// File: rtl/rdsrb_edge.sv
module rdsrb_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic enable,
    input  logic pin_in,
    output logic fall
);

    logic [SYNC_STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[SYNC_STAGES-1:0], pin_in};
        end
    end

    assign fall = run && enable && sh[SYNC_STAGES] && !sh[SYNC_STAGES-1];

endmodule

// File: rtl/rds_readout_buffer.sv
module rds_readout_buffer
    import rdsrb_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int HALF_CYCLES = 1824,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_data,
    input  logic bit_rel,
    input  logic mode_sel,
    input  logic test_sel,
    input  logic sclk_in,
    output logic sclk_out,
    output logic sclk_oe,
    output logic sdata_out,
    output logic flag_out
);

    opmode_e       op;
    logic          run;
    logic          master_en;
    logic          slave_en;
    rds_bit_t      wr_entry;
    rds_bit_t      head;
    logic [CW-1:0] fill_cnt;
    logic          armed_q;
    logic          m_pop;
    logic          s_fall;
    logic          m_sclk;
    logic          m_data;
    logic          m_rel;

    assign op        = decode_op(test_sel, mode_sel);
    assign run       = !test_sel;
    assign master_en = (op == OP_MASTER);
    assign slave_en  = (op == OP_SLAVE);
    assign wr_entry  = '{data: bit_data, rel: bit_rel};

    rdsrb_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .wr_valid (bit_valid),
        .wr_entry (wr_entry),
        .pop      (m_pop || s_fall),
        .head     (head),
        .fill     (fill_cnt),
        .armed    (armed_q)
    );

    rdsrb_master #(.HALF_CYCLES(HALF_CYCLES)) u_master (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .enable (master_en),
        .armed  (armed_q),
        .avail  (fill_cnt != '0),
        .head   (head),
        .pop    (m_pop),
        .sclk   (m_sclk),
        .sdata  (m_data),
        .rel    (m_rel)
    );

    rdsrb_edge #(.SYNC_STAGES(2)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .enable (slave_en),
        .pin_in (sclk_in),
        .fall   (s_fall)
    );

    always_comb begin
        sclk_oe   = 1'b0;
        sclk_out  = 1'b0;
        sdata_out = 1'b0;
        flag_out  = 1'b0;
        case (op)
            OP_MASTER: begin
                sclk_oe   = 1'b1;
                sclk_out  = m_sclk;
                sdata_out = m_data;
                flag_out  = m_rel;
            end
            OP_SLAVE: begin
                sdata_out = head.data;
                flag_out  = (fill_cnt != '0);
            end
            default: begin
                sclk_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rdsrb_checker.sv
module rdsrb_checker #(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          test_sel,
    input logic          mode_sel,
    input logic          sclk_out,
    input logic          sdata_out,
    input logic [CW-1:0] fill,
    input logic          armed
);

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |=> (fill <= CW'(1)));

    p_armed_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);

    p_prearm_high_r6: assert property (@(posedge clk) disable iff (rst)
        (!armed && !test_sel && !mode_sel) |-> (sclk_out && sdata_out));

    p_fall_data_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!test_sel && !mode_sel && $past(!test_sel && !mode_sel) && $fell(sclk_out))
        |-> $stable(sdata_out));

    p_standby_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(test_sel) && !$past(rst)) |-> $stable(fill));

endmodule

bind rds_readout_buffer rdsrb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .test_sel  (test_sel),
    .mode_sel  (mode_sel),
    .sclk_out  (sclk_out),
    .sdata_out (sdata_out),
    .fill      (fill_cnt),
    .armed     (armed_q)
);

// File: tb/rds_readout_buffer_tb_top.sv
module rds_readout_buffer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int HALF       = 6;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic bit_data = 1'b0;
    logic bit_rel = 1'b0;
    logic mode_sel = 1'b0;
    logic test_sel = 1'b0;
    logic sclk_in = 1'b0;
    logic sclk_out, sclk_oe, sdata_out, flag_out;

    int          n_chk = 0;
    int          n_bad = 0;
    int unsigned cyc = 0;
    logic [1:0]  mq[$];
    logic        m_armed = 1'b0;

    rds_readout_buffer #(.DEPTH(DEPTH), .HALF_CYCLES(HALF)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .bit_rel   (bit_rel),
        .mode_sel  (mode_sel),
        .test_sel  (test_sel),
        .sclk_in   (sclk_in),
        .sclk_out  (sclk_out),
        .sclk_oe   (sclk_oe),
        .sdata_out (sdata_out),
        .flag_out  (flag_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model_push(logic d, logic r);
        if (!m_armed && !r) return;
        m_armed = 1'b1;
        mq.push_back({d, r});
        if (mq.size() > DEPTH) void'(mq.pop_front());
    endfunction

    function automatic logic rnd_bit();
        return 1'($urandom_range(0, 1));
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        mq.delete();
        m_armed = 1'b0;
        tick(1);
    endtask

    task automatic write_bit(logic d, logic r);
        bit_valid = 1'b1;
        bit_data  = d;
        bit_rel   = r;
        @(negedge clk);
        bit_valid = 1'b0;
        if (!test_sel) model_push(d, r);
    endtask

    task automatic slave_read(string req);
        logic [1:0] e;
        e = mq.pop_front();
        chk({req, " ready before read"}, int'(flag_out), 1);
        chk({req, " slave data"}, int'(sdata_out), int'(e[1]));
        sclk_in = 1'b1;
        tick(4);
        chk("R8 rising edge keeps data", int'(sdata_out), int'(e[1]));
        sclk_in = 1'b0;
        tick(4);
    endtask

    task automatic master_read(string req, output int fall_at);
        logic       prev;
        logic [1:0] e;
        int         guard;
        guard   = 0;
        fall_at = 0;
        prev    = sclk_out;
        forever begin
            tick(1);
            if (prev && !sclk_out) break;
            prev = sclk_out;
            guard++;
            if (guard > 10 * HALF) begin
                chk({req, " master fall seen"}, 0, 1);
                return;
            end
        end
        fall_at = int'(cyc);
        e = mq.pop_front();
        chk({req, " master data"}, int'(sdata_out), int'(e[1]));
        chk({req, " master rel flag"}, int'(flag_out), int'(e[0]));
        chk("R4 clock driven", int'(sclk_oe), 1);
    endtask

    initial begin
        int f1, f2, f3, bad;
        void'($urandom(32'd4711));

        // R1 / R6: reset in master readout
        mode_sel = 1'b0;
        do_reset();
        chk("R6 sclk high after reset", int'(sclk_out), 1);
        chk("R6 sdata high after reset", int'(sdata_out), 1);
        chk("R1 flag low after reset", int'(flag_out), 0);
        repeat (3) write_bit(rnd_bit(), 1'b0);
        bad = 0;
        for (int i = 0; i < 3 * HALF; i++) begin
            tick(1);
            if (!sclk_out || !sdata_out) bad++;
        end
        chk("R6 outputs high before arming", bad, 0);
        mode_sel = 1'b1;
        tick(2);
        chk("R2 unreliable bits discarded", int'(flag_out), 0);
        chk("R7 clock released in slave", int'(sclk_oe), 0);

        // R2 / R7 / R8: arm then read in slave mode
        write_bit(1'b1, 1'b1);
        for (int i = 0; i < 5; i++) write_bit(rnd_bit(), rnd_bit());
        tick(1);
        chk("R7 ready with stored bits", int'(flag_out), 1);
        for (int i = 0; i < 6; i++) slave_read("R2");
        chk("R7 ready low when drained", int'(flag_out), 0);

        // R9: edges while empty are ignored
        for (int i = 0; i < 3; i++) begin
            sclk_in = 1'b1; tick(4);
            sclk_in = 1'b0; tick(4);
        end
        chk("R9 still not ready", int'(flag_out), 0);
        write_bit(rnd_bit(), 1'b0);
        tick(1);
        slave_read("R9");
        chk("R9 drained", int'(flag_out), 0);

        // R3: overwrite when full
        for (int i = 0; i < DEPTH + 5; i++) write_bit(rnd_bit(), rnd_bit());
        tick(1);
        for (int i = 0; i < DEPTH; i++) slave_read("R3");
        chk("R3 empty after DEPTH reads", int'(flag_out), 0);

        // R11: standby freezes everything
        for (int i = 0; i < 3; i++) write_bit(rnd_bit(), rnd_bit());
        test_sel = 1'b1;
        tick(2);
        chk("R11 clock not driven", int'(sclk_oe), 0);
        chk("R11 flag low", int'(flag_out), 0);
        chk("R11 data low", int'(sdata_out), 0);
        write_bit(1'b1, 1'b1);
        write_bit(1'b0, 1'b1);
        sclk_in = 1'b1; tick(4);
        sclk_in = 1'b0; tick(4);
        test_sel = 1'b0;
        tick(2);
        for (int i = 0; i < 3; i++) slave_read("R11");
        chk("R11 no extra bits stored", int'(flag_out), 0);

        // R4 / R10: master reads three, then slave continues
        for (int i = 0; i < 6; i++) write_bit(rnd_bit(), rnd_bit());
        mode_sel = 1'b0;
        master_read("R4", f1);
        master_read("R4", f2);
        master_read("R4", f3);
        mode_sel = 1'b1;
        chk("R4 bit period first", f2 - f1, 2 * HALF);
        chk("R4 bit period second", f3 - f2, 2 * HALF);
        tick(2);
        for (int i = 0; i < 3; i++) slave_read("R10");
        chk("R10 drained after switch", int'(flag_out), 0);

        // R10 / R5: slave reads one, master continues, then idles high
        for (int i = 0; i < 4; i++) write_bit(rnd_bit(), rnd_bit());
        tick(1);
        slave_read("R10");
        mode_sel = 1'b0;
        master_read("R10", f1);
        master_read("R10", f2);
        master_read("R10", f3);
        tick(HALF + 2);
        bad = 0;
        for (int i = 0; i < 4 * HALF; i++) begin
            tick(1);
            if (!sclk_out) bad++;
        end
        chk("R5 clock held high when empty", bad, 0);
        chk("R4 clock enable in master", int'(sclk_oe), 1);

        // R1 / R2: reset mid-stream clears and re-gates
        mode_sel = 1'b1;
        for (int i = 0; i < 3; i++) write_bit(rnd_bit(), 1'b1);
        do_reset();
        chk("R1 ready cleared by reset", int'(flag_out), 0);
        write_bit(1'b1, 1'b0);
        tick(1);
        chk("R2 gated again after reset", int'(flag_out), 0);
        write_bit(1'b0, 1'b1);
        tick(1);
        chk("R2 arming bit stored", int'(flag_out), 1);
        slave_read("R2");

        summary();
        $finish;
    end

endmodule